// File: doc/BRIEF.md
# Channel I/O Interruption Arbiter

This block sits between a set of I/O channels and the processor's interruption sequencer. Each channel raises a one-cycle request pulse when it has an interruption condition to present. The block keeps that request pending until the processor accepts it. It decides which channels the current program state allows to interrupt, and picks one eligible request at a time. The winning channel is granted only at the end of a unit of operation.

The enable rule depends on the control mode of the current program status word. In the extended mode, every channel is gated by the general I/O mask bit together with its own bit in the channel-mask control register image. In the basic mode, the six lowest channels are gated only by six dedicated mask bits of the status word. The higher channels keep the I/O-mask-and-register rule, and the register's six low bits play no part.

While a grant is held, the block presents the interrupting address (channel number above device number). It also presents the storage locations the handler sequence writes to and reads from: the old status word slot, the channel status word slot and the new status word slot. It further shows where the interrupting address is to be placed, which is either low storage (with a zero byte ahead of it) or the status word's code field.

Top module: `io_intr_arbiter`

## Requirements
- R1: In extended mode (`ec_mode_i`=1), channel k is eligible exactly when `psw_io_mask_i` is 1 and `cr2_i[k]` is 1.
- R2: In basic mode (`ec_mode_i`=0), channel k for k below 6 is eligible exactly when `psw_chan_mask_i[k]` is 1, whatever `psw_io_mask_i` and `cr2_i[k]` are.
- R3: In basic mode, channel k for k of 6 or more is eligible exactly when `psw_io_mask_i` and `cr2_i[k]` are both 1.
- R4: A pulse on `req_i[k]` makes channel k pending from the next cycle on. The channel stays pending, even while it is not eligible, until it is accepted.
- R5: A grant is made only at a clock edge where `unit_done_i` is 1, no grant is outstanding, and at least one pending channel is eligible. At most one bit of `grant_o` is ever set.
- R6: Among the eligible pending channels, the lowest-numbered one is granted.
- R7: A grant stays unchanged, whatever the masks, requests or `unit_done_i` do, until `accept_i` is 1 at a clock edge. That edge clears the grant and the granted channel's pending state. `accept_i` with no grant outstanding has no effect.
- R8: While a grant is held, `io_addr_o` equals the channel number in bits 15:8 and that channel's `dev_i` byte, as seen at grant time, in bits 7:0. It is zero otherwise.
- R9: While a grant is held, `old_psw_loc_o`=56, `csw_loc_o`=64 and `new_psw_loc_o`=120. With no grant all three are zero.
- R10: `addr_dest_o` is 0 with no grant. It is 1 (low storage) when the grant was made in extended mode, and then `addr_loc_o`=186 and `zero_loc_o`=185. It is 2 (status word code field) when the grant was made in basic mode, and then both location outputs are zero.
- R11: After synchronous reset, nothing is pending and no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_CH | Per-channel request pulses |
| dev_i | input | NUM_CH*DEV_W | Device number of each channel, channel k at bits k*DEV_W upward |
| psw_chan_mask_i | input | 6 | Basic-mode mask bits for channels 0 to 5 |
| psw_io_mask_i | input | 1 | General I/O mask bit of the status word |
| ec_mode_i | input | 1 | 1 = extended mode, 0 = basic mode |
| cr2_i | input | 32 | Channel-mask control register image, bit k for channel k |
| unit_done_i | input | 1 | Unit of operation complete |
| accept_i | input | 1 | Sequencer takes the granted interruption |
| grant_o | output | NUM_CH | One-hot granted channel |
| grant_valid_o | output | 1 | A grant is held |
| io_addr_o | output | CH_W+DEV_W | Interrupting channel and device address |
| old_psw_loc_o | output | 12 | Where the old status word is stored |
| csw_loc_o | output | 12 | Where the channel status word is stored |
| new_psw_loc_o | output | 12 | Where the new status word is fetched from |
| addr_loc_o | output | 12 | Low-storage location for the address |
| zero_loc_o | output | 12 | Location of the zero byte ahead of the address |
| addr_dest_o | output | 2 | Address destination: 0 none, 1 low storage, 2 status word |

## Verification
The hardest situation to reach is a grant that must hold still while everything around it moves. In that case a lower-numbered channel turns pending, the masks withdraw eligibility from the granted channel, and further unit-complete strobes arrive, all before the accept. The bench reaches it by granting a channel and then, over several cycles, pulsing a lower request, flipping mode and masks, and holding the unit-complete strobe high. It then accepts on a cycle that also carries that strobe, and checks that the newer, lower request wins only at the following completion. A second sweep covers every mode, mask and register-bit combination on every channel one at a time. A third covers all 255 request subsets, draining each in priority order.

// File: rtl/ioarb_pkg.sv
package ioarb_pkg;

    localparam int LOC_W       = 12;
    localparam int BC_LOW_CH   = 6;
    localparam int CR_W        = 32;

    localparam int OLD_PSW_LOC = 56;
    localparam int CSW_LOC     = 64;
    localparam int NEW_PSW_LOC = 120;
    localparam int ZERO_LOC    = 185;
    localparam int ADDR_LOC    = 186;

    typedef enum logic [1:0] {
        DEST_NONE    = 2'd0,
        DEST_LOWCORE = 2'd1,
        DEST_PSW     = 2'd2
    } addr_dest_e;

    typedef struct packed {
        logic                 ec;
        logic                 io_mask;
        logic [BC_LOW_CH-1:0] low_mask;
    } psw_ctl_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/io_enable_mask.sv
module io_enable_mask
    import ioarb_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  psw_ctl_t          psw,
    input  logic [NUM_CH-1:0] cr2_bits,
    output logic [NUM_CH-1:0] enable
);
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        if (k < BC_LOW_CH) begin : g_low
            assign enable[k] = psw.ec ? (psw.io_mask & cr2_bits[k]) : psw.low_mask[k];
        end else begin : g_high
            assign enable[k] = psw.io_mask & cr2_bits[k];
        end
    end
endmodule

// File: rtl/io_pending.sv
module io_pending #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] set_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] pend_o
);
    logic [NUM_CH-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q | set_i) & ~clr_i;
    end

    assign pend_o = pend_q;

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

    // R4
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
endmodule

// File: rtl/io_prio_pick.sv
module io_prio_pick
    import ioarb_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int IDX_W = idx_width(NUM_CH)
) (
    input  logic [NUM_CH-1:0] cand,
    output logic              any,
    output logic [IDX_W-1:0]  idx,
    output logic [NUM_CH-1:0] onehot
);
    always_comb begin
        idx = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (cand[k]) idx = IDX_W'(k);
        end
    end

    assign any    = |cand;
    assign onehot = any ? (NUM_CH'(1) << idx) : '0;
endmodule

// File: rtl/io_loc_map.sv
module io_loc_map
    import ioarb_pkg::*;
(
    input  logic             valid,
    input  logic             ec,
    output logic [LOC_W-1:0] old_psw_loc,
    output logic [LOC_W-1:0] csw_loc,
    output logic [LOC_W-1:0] new_psw_loc,
    output logic [LOC_W-1:0] addr_loc,
    output logic [LOC_W-1:0] zero_loc,
    output addr_dest_e       dest
);
    always_comb begin
        old_psw_loc = '0;
        csw_loc     = '0;
        new_psw_loc = '0;
        addr_loc    = '0;
        zero_loc    = '0;
        dest        = DEST_NONE;
        if (valid) begin
            old_psw_loc = LOC_W'(OLD_PSW_LOC);
            csw_loc     = LOC_W'(CSW_LOC);
            new_psw_loc = LOC_W'(NEW_PSW_LOC);
            if (ec) begin
                dest     = DEST_LOWCORE;
                addr_loc = LOC_W'(ADDR_LOC);
                zero_loc = LOC_W'(ZERO_LOC);
            end else begin
                dest = DEST_PSW;
            end
        end
    end
endmodule

// File: rtl/io_intr_arbiter.sv
module io_intr_arbiter
    import ioarb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DEV_W  = 8,
    parameter int CH_W   = 8,
    localparam int IDX_W  = idx_width(NUM_CH),
    localparam int ADDR_W = CH_W + DEV_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       req_i,
    input  logic [NUM_CH*DEV_W-1:0] dev_i,
    input  logic [BC_LOW_CH-1:0]    psw_chan_mask_i,
    input  logic                    psw_io_mask_i,
    input  logic                    ec_mode_i,
    input  logic [CR_W-1:0]         cr2_i,
    input  logic                    unit_done_i,
    input  logic                    accept_i,
    output logic [NUM_CH-1:0]       grant_o,
    output logic                    grant_valid_o,
    output logic [ADDR_W-1:0]       io_addr_o,
    output logic [LOC_W-1:0]        old_psw_loc_o,
    output logic [LOC_W-1:0]        csw_loc_o,
    output logic [LOC_W-1:0]        new_psw_loc_o,
    output logic [LOC_W-1:0]        addr_loc_o,
    output logic [LOC_W-1:0]        zero_loc_o,
    output logic [1:0]              addr_dest_o
);
    psw_ctl_t          psw;
    logic [NUM_CH-1:0] enable;
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] clr_vec;
    logic [NUM_CH-1:0] pick_oh;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;
    logic              take;
    addr_dest_e        dest;

    logic [NUM_CH-1:0] grant_q;
    logic [IDX_W-1:0]  gidx_q;
    logic [DEV_W-1:0]  gdev_q;
    logic              gec_q;
    logic              gvalid_q;

    logic unused_inputs;
    assign unused_inputs = ^{cr2_i, psw_chan_mask_i};

    assign psw = '{ec: ec_mode_i, io_mask: psw_io_mask_i, low_mask: psw_chan_mask_i};

    io_enable_mask #(.NUM_CH(NUM_CH)) u_enable (
        .psw      (psw),
        .cr2_bits (cr2_i[NUM_CH-1:0]),
        .enable   (enable)
    );

    assign clr_vec = (accept_i && gvalid_q) ? grant_q : '0;

    io_pending #(.NUM_CH(NUM_CH)) u_pending (
        .clk    (clk),
        .rst    (rst),
        .set_i  (req_i),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    io_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
        .cand   (pend & enable),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    assign take = unit_done_i && !gvalid_q && pick_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q  <= '0;
            gidx_q   <= '0;
            gdev_q   <= '0;
            gec_q    <= 1'b0;
            gvalid_q <= 1'b0;
        end else if (gvalid_q) begin
            if (accept_i) begin
                grant_q  <= '0;
                gvalid_q <= 1'b0;
            end
        end else if (take) begin
            grant_q  <= pick_oh;
            gidx_q   <= pick_idx;
            gdev_q   <= dev_i[pick_idx*DEV_W +: DEV_W];
            gec_q    <= ec_mode_i;
            gvalid_q <= 1'b1;
        end
    end

    io_loc_map u_locs (
        .valid       (gvalid_q),
        .ec          (gec_q),
        .old_psw_loc (old_psw_loc_o),
        .csw_loc     (csw_loc_o),
        .new_psw_loc (new_psw_loc_o),
        .addr_loc    (addr_loc_o),
        .zero_loc    (zero_loc_o),
        .dest        (dest)
    );

    assign grant_o       = grant_q;
    assign grant_valid_o = gvalid_q;
    assign io_addr_o     = gvalid_q ? {CH_W'(gidx_q), gdev_q} : '0;
    assign addr_dest_o   = dest;

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q) && (gvalid_q == (grant_q != '0)));

    // R5
    grant_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gvalid_q) |-> $past(unit_done_i));

    // R6
    grant_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gvalid_q) |-> (((grant_q & $past(pend & enable)) != '0) &&
                             (($past(pend & enable) & (grant_q - NUM_CH'(1))) == '0)));

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gvalid_q && !accept_i) |=> ($stable(grant_q) && $stable(io_addr_o)));

    // R7
    grant_release_chk: assert property (@(posedge clk) disable iff (rst)
        (gvalid_q && accept_i) |=> (!gvalid_q && ((pend & $past(grant_q & ~req_i)) == '0)));

    // R10
    dest_mode_chk: assert property (@(posedge clk) disable iff (rst)
        gvalid_q |-> ((addr_dest_o == 2'(DEST_LOWCORE)) == gec_q));

    // R9
    locs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !gvalid_q |-> (new_psw_loc_o == '0 && addr_dest_o == 2'(DEST_NONE) && io_addr_o == '0));
endmodule

// File: tb/io_intr_arbiter_tb.sv
module io_intr_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  req_i;
    logic [N*8-1:0] dev_i;
    logic [5:0]    psw_chan_mask_i;
    logic          psw_io_mask_i;
    logic          ec_mode_i;
    logic [31:0]   cr2_i;
    logic          unit_done_i;
    logic          accept_i;
    logic [N-1:0]  grant_o;
    logic          grant_valid_o;
    logic [15:0]   io_addr_o;
    logic [11:0]   old_psw_loc_o, csw_loc_o, new_psw_loc_o, addr_loc_o, zero_loc_o;
    logic [1:0]    addr_dest_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_intr_arbiter u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .dev_i(dev_i),
        .psw_chan_mask_i(psw_chan_mask_i), .psw_io_mask_i(psw_io_mask_i),
        .ec_mode_i(ec_mode_i), .cr2_i(cr2_i), .unit_done_i(unit_done_i),
        .accept_i(accept_i), .grant_o(grant_o), .grant_valid_o(grant_valid_o),
        .io_addr_o(io_addr_o), .old_psw_loc_o(old_psw_loc_o), .csw_loc_o(csw_loc_o),
        .new_psw_loc_o(new_psw_loc_o), .addr_loc_o(addr_loc_o), .zero_loc_o(zero_loc_o),
        .addr_dest_o(addr_dest_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pend(input logic [N-1:0] m);
        req_i = m; tick(); req_i = '0;
    endtask

    task automatic take();
        unit_done_i = 1'b1; tick(); unit_done_i = 1'b0;
    endtask

    task automatic acc();
        accept_i = 1'b1; tick(); accept_i = 1'b0;
    endtask

    task automatic open_all(input logic ec);
        ec_mode_i = ec; psw_io_mask_i = 1'b1; psw_chan_mask_i = 6'h3f; cr2_i = 32'hffff_ffff;
    endtask

    function automatic logic [15:0] exp_addr(input int k);
        return {8'(k), 8'(k * 17 + 3)};
    endfunction

    task automatic chk_grant(input string tag, input int k, input logic ec);
        chk({tag, " grant"}, 32'(grant_o), 32'(1 << k));
        chk({"R8 addr"}, 32'(io_addr_o), 32'(exp_addr(k)));
        chk({"R9 old"}, 32'(old_psw_loc_o), 32'd56);
        chk({"R9 csw"}, 32'(csw_loc_o), 32'd64);
        chk({"R9 new"}, 32'(new_psw_loc_o), 32'd120);
        chk({"R10 dest"}, 32'(addr_dest_o), ec ? 32'd1 : 32'd2);
        chk({"R10 addrloc"}, 32'(addr_loc_o), ec ? 32'd186 : 32'd0);
        chk({"R10 zeroloc"}, 32'(zero_loc_o), ec ? 32'd185 : 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) dev_i[k*8 +: 8] = 8'(k * 17 + 3);
        req_i = '0; unit_done_i = 0; accept_i = 0;
        open_all(1'b1);
        rst = 1'b1;
        @(negedge clk); tick();
        rst = 1'b0;

        // R11 reset state
        chk("R11 valid", 32'(grant_valid_o), 0);
        chk("R11 grant", 32'(grant_o), 0);
        take();
        chk("R11 nothing pending", 32'(grant_valid_o), 0);
        chk("R9 idle loc", 32'(old_psw_loc_o), 0);
        chk("R10 idle dest", 32'(addr_dest_o), 0);

        // R1 R2 R3 enable sweep, one channel at a time
        for (int ec = 0; ec < 2; ec++)
            for (int k = 0; k < N; k++)
                for (int c = 0; c < 8; c++) begin
                    logic io, cr, pb, en;
                    io = c[0]; cr = c[1]; pb = c[2];
                    en = (ec == 1) ? (io & cr) : ((k < 6) ? pb : (io & cr));
                    ec_mode_i = 1'(ec); psw_io_mask_i = io;
                    psw_chan_mask_i = pb ? 6'h3f : 6'h00;
                    cr2_i = cr ? 32'hffff_ffff : 32'h0;
                    pend(N'(1) << k);
                    take();
                    if (ec == 1)     chk("R1 enable", 32'(grant_valid_o), 32'(en));
                    else if (k < 6)  chk("R2 enable", 32'(grant_valid_o), 32'(en));
                    else             chk("R3 enable", 32'(grant_valid_o), 32'(en));
                    if (en) chk("R6 single", 32'(grant_o), 32'(1 << k));
                    if (!en) begin
                        open_all(1'b0);
                        take();
                        chk("R4 kept while masked", 32'(grant_o), 32'(1 << k));
                    end
                    acc();
                    chk("R7 cleared", 32'(grant_valid_o), 0);
                end

        // R3 basic mode: cr2 low bits ignored, mixed pattern
        ec_mode_i = 0; psw_io_mask_i = 1; psw_chan_mask_i = 6'b000100; cr2_i = 32'h0000_003b;
        pend(8'h3f);
        take();
        chk("R3 low cr2 ignored", 32'(grant_o), 32'h04);
        acc(); take();
        chk("R3 only ch2 eligible", 32'(grant_valid_o), 0);
        open_all(1'b1);
        for (int k = 0; k < 6; k++) if (k != 2) begin take(); acc(); end
        take();
        chk("R4 drained", 32'(grant_valid_o), 0);

        // R6 R8 R9 R10 all request subsets drained in priority order
        for (int p = 1; p < 256; p++) begin
            logic [N-1:0] rem;
            logic pe;
            pe = p[0];
            open_all(pe);
            rem = N'(p);
            pend(rem);
            while (rem != 0) begin
                int lo;
                lo = 0;
                for (int b = N - 1; b >= 0; b--) if (rem[b]) lo = b;
                take();
                chk_grant("R6", lo, pe);
                acc();
                rem[lo] = 1'b0;
            end
            take();
            chk("R7 all cleared", 32'(grant_valid_o), 0);
        end

        // R5 no grant without unit_done
        open_all(1'b1);
        pend(8'h06);
        tick(); tick();
        chk("R5 no done no grant", 32'(grant_valid_o), 0);
        take();
        chk("R5 grant on done", 32'(grant_o), 32'h02);
        // R7 hold under churn
        unit_done_i = 1;
        pend(8'h01);
        ec_mode_i = 0; psw_chan_mask_i = 6'h00; psw_io_mask_i = 0; cr2_i = 0;
        tick(); tick();
        chk("R7 hold grant", 32'(grant_o), 32'h02);
        chk("R7 hold addr", 32'(io_addr_o), 32'(exp_addr(1)));
        chk("R10 captured mode", 32'(addr_dest_o), 1);
        accept_i = 1; tick(); accept_i = 0;
        chk("R7 accept with done", 32'(grant_valid_o), 0);
        open_all(1'b1);
        tick();
        unit_done_i = 0;
        chk("R6 newer lower wins", 32'(grant_o), 32'h01);
        acc(); take();
        chk("R6 then ch2", 32'(grant_o), 32'h04);
        acc();

        // R7 accept without grant has no effect
        pend(8'h10);
        acc();
        chk("R7 stray accept", 32'(grant_valid_o), 0);
        take();
        chk("R7 pending survives stray accept", 32'(grant_o), 32'h10);
        acc();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule